// File: doc/BRIEF.md
# SMBus Clock-Low Timeout and Bus-Idle Detector

This block watches the two SMBus wires, already synchronised to the system clock, and reports two line conditions. The first condition is a clock-low timeout. A 16-bit counter is parked at a software-chosen start value while SCL is high. It advances by one on every system clock while SCL is low. When it steps past its all-ones value it has overflowed, which means the clock wire has been held low for too long. Software picks the start value so that the overflow lands near the 25 ms limit that SMBus sets.

The second condition is bus idle. It is reported once both wires have stayed high for more than a fixed number of SMBus clock-source ticks (10 by default). Each detector has its own enable.

The timeout is reported in two ways: a sticky flag that software clears with a pulse, and a one-cycle interrupt strobe. Idle is reported as a plain level. No data flows through the block, so every pin is a plain control or status line with no handshake. Recovering the bus after a timeout is left to the logic outside this block.

Top module: `smb_line_watch`

## Requirements
- R1: While `tmo_en_i` is 1 and SCL is high, the low counter is loaded with `tmo_reload_i` on every clock. A value changed during a high phase is the one used by the next low phase.
- R2: While `tmo_en_i` is 1 and SCL is low, the counter steps up by one per clock. A low phase that spans fewer than N = 2^16 − `tmo_reload_i` clock edges produces no interrupt and leaves the flag at 0.
- R3: The N-th consecutive low edge is the overflow. `tmo_irq_o` is 1 for exactly the one cycle after that edge, and the counter restarts from `tmo_reload_i`. An unbroken low of L edges therefore gives floor(L/N) interrupt pulses.
- R4: `tmo_flag_o` is set together with each interrupt pulse. It stays at 1 until a clock edge samples `tmo_clr_i` = 1. If an overflow and a clear arrive on the same edge, the overflow wins.
- R5: While `tmo_en_i` is 0, the counter is held at the reload value, no interrupt is issued, and the flag is forced to 0 from the next cycle on.
- R6: While `idle_en_i` is 1, each clock edge that samples `cs_tick_i` = 1 with SCL and SDA both high adds one to the idle count. Edges without a tick add nothing. `bus_idle_o` rises in the cycle after the (IDLE_TICKS+1)-th counted tick and then holds.
- R7: Any edge that samples SCL or SDA low clears the idle count, so `bus_idle_o` is 0 in the following cycle. Becoming idle again needs IDLE_TICKS+1 fresh ticks.
- R8: While `idle_en_i` is 0, the idle count is cleared and `bus_idle_o` is 0 from the next cycle on.
- R9: During and directly after reset, `tmo_flag_o`, `tmo_irq_o` and `bus_idle_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| tmo_en_i | input | 1 | Enable for the clock-low timeout detector |
| idle_en_i | input | 1 | Enable for the bus-idle detector |
| cs_tick_i | input | 1 | One-cycle SMBus clock-source tick |
| tmo_reload_i | input | TMO_W | Start value of the low counter |
| tmo_clr_i | input | 1 | Clears the sticky timeout flag |
| tmo_flag_o | output | 1 | Sticky clock-low timeout flag |
| tmo_irq_o | output | 1 | One-cycle timeout interrupt strobe |
| bus_idle_o | output | 1 | Both lines idle-high for long enough |

## Verification
A low counter holding a wrong value shows up as an interrupt strobe that arrives too early or too late. The error appears within one low phase, so the bench sweeps the low length edge by edge across several reload values and counts the strobes against floor(L/N). A counter that fails to restart after an overflow shows as a wrong count on the longer lows. An idle count that is off by one moves the rising edge of `bus_idle_o` by one tick, which the bench catches by checking the level after the 10th and after the 11th tick. A count that is not cleared shows as `bus_idle_o` staying high, or coming back too fast, after a one-cycle pulse low on SDA.

// File: rtl/smb_watch_pkg.sv
package smb_watch_pkg;
  localparam int unsigned TMO_W_DEF      = 16;
  localparam int unsigned IDLE_TICKS_DEF = 10;

  typedef enum logic [1:0] {
    LOW_HOLD  = 2'd0,
    LOW_STEP  = 2'd1,
    LOW_WRAP  = 2'd2
  } low_act_e;
endpackage

// File: rtl/smb_low_timer.sv
module smb_low_timer
  import smb_watch_pkg::*;
#(
  parameter int unsigned TMO_W = TMO_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scl_i,
  input  logic [TMO_W-1:0] reload_i,
  output logic             wrap_o
);
  localparam logic [TMO_W-1:0] CNT_TOP = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;
  low_act_e         act;

  // Choose what the counter does on this edge
  always_comb begin
    if (!en_i || scl_i)       act = LOW_HOLD;
    else if (cnt_q == CNT_TOP) act = LOW_WRAP;
    else                      act = LOW_STEP;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (act)
        LOW_STEP: cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= reload_i;
      endcase
    end
  end

  assign wrap_o = (act == LOW_WRAP);

  AST_RELOAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && scl_i) |=> (cnt_q == $past(reload_i))); // R1
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !scl_i && cnt_q != CNT_TOP) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_WRAP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(reload_i))); // R3
endmodule

// File: rtl/smb_tmo_flag.sv
module smb_tmo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic irq_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (!en_i) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= wrap_i;
      if (wrap_i)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && en_i && !clr_i) |=> flag_o); // R4
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!irq_o && !flag_o)); // R5
endmodule

// File: rtl/smb_idle_detect.sv
module smb_idle_detect
  import smb_watch_pkg::*;
#(
  parameter int unsigned IDLE_TICKS = IDLE_TICKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tick_i,
  output logic idle_o
);
  localparam int unsigned GOAL  = IDLE_TICKS + 1;
  localparam int unsigned CNT_W = $clog2(GOAL + 1);
  localparam logic [CNT_W-1:0] GOAL_V = CNT_W'(GOAL);

  logic [CNT_W-1:0] cnt_q;
  logic             lines_high;

  assign lines_high = scl_i && sda_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || !lines_high) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != GOAL_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle_o = (cnt_q == GOAL_V);

  AST_IDLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_i || !sda_i) |=> !idle_o); // R7
  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !idle_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && en_i && scl_i && sda_i) |=> idle_o); // R6
endmodule

// File: rtl/smb_line_watch.sv
module smb_line_watch
  import smb_watch_pkg::*;
#(
  parameter int unsigned TMO_W      = TMO_W_DEF,
  parameter int unsigned IDLE_TICKS = IDLE_TICKS_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             tmo_en_i,
  input  logic             idle_en_i,
  input  logic             cs_tick_i,
  input  logic [TMO_W-1:0] tmo_reload_i,
  input  logic             tmo_clr_i,
  output logic             tmo_flag_o,
  output logic             tmo_irq_o,
  output logic             bus_idle_o
);
  logic wrap;

  smb_low_timer #(.TMO_W(TMO_W)) u_low (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tmo_en_i),
    .scl_i    (scl_i),
    .reload_i (tmo_reload_i),
    .wrap_o   (wrap)
  );

  smb_tmo_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tmo_en_i),
    .wrap_i (wrap),
    .clr_i  (tmo_clr_i),
    .flag_o (tmo_flag_o),
    .irq_o  (tmo_irq_o)
  );

  smb_idle_detect #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (idle_en_i),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .tick_i (cs_tick_i),
    .idle_o (bus_idle_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (!tmo_flag_o && !tmo_irq_o && !bus_idle_o)); // R9
endmodule

// File: tb/smb_line_watch_tb.sv
module smb_line_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, sda = 1'b1;
  logic        tmo_en = 1'b0, idle_en = 1'b0, tick = 1'b0, clr = 1'b0;
  logic [15:0] reload = 16'hFFF0;
  logic        flag, irq, idle;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  smb_line_watch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .tmo_en_i(tmo_en), .idle_en_i(idle_en), .cs_tick_i(tick),
    .tmo_reload_i(reload), .tmo_clr_i(clr),
    .tmo_flag_o(flag), .tmo_irq_o(irq), .bus_idle_o(idle)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Hold SCL low for len edges and return the number of strobes seen
  task automatic low_run(input int len, output int pulses);
    pulses = 0;
    scl = 1'b0;
    for (int i = 0; i < len; i++) begin
      step();
      if (irq) pulses++;
    end
    scl = 1'b1;
    step();
    if (irq) pulses++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int p;
    int n;
    logic [15:0] rl [4] = '{16'hFFF0, 16'hFFF8, 16'hFFFE, 16'hFFFF};
    @(negedge clk);
    step();
    check("R9 flag in reset", flag, 0);
    check("R9 irq in reset", irq, 0);
    check("R9 idle in reset", idle, 0);
    rst_n = 1'b1;
    step();
    check("R9 idle after reset", idle, 0);
    tmo_en = 1'b1;
    step();
    step();
    // N = 16 edges
    low_run(15, p);
    check("R2 short low strobes", p, 0);
    check("R2 short low flag", flag, 0);
    low_run(16, p);
    check("R3 one strobe at N", p, 1);
    check("R4 flag set", flag, 1);
    repeat (5) step();
    check("R4 flag sticky", flag, 1);
    clr = 1'b1; step(); clr = 1'b0;
    check("R4 flag cleared", flag, 0);
    // Overflow and clear on the same edge: overflow wins
    scl = 1'b0;
    repeat (15) step();
    clr = 1'b1; step(); clr = 1'b0;
    check("R4 set beats clear irq", irq, 1);
    check("R4 set beats clear flag", flag, 1);
    scl = 1'b1; step();
    clr = 1'b1; step(); clr = 1'b0;
    // Sweep reload values and low lengths
    foreach (rl[k]) begin
      reload = rl[k];
      step();
      n = 65536 - int'(rl[k]);
      for (int len = 1; len <= 40; len++) begin
        low_run(len, p);
        check($sformatf("R3 R1 strobes rl=%h len=%0d", rl[k], len), p, len / n);
        check("R4 flag after run", flag, (len >= n) ? 1 : 0);
        clr = 1'b1; step(); clr = 1'b0;
      end
    end
    reload = 16'hFFF0;
    step();
    // Detector off
    low_run(10, p);
    tmo_en = 1'b0;
    step();
    low_run(40, p);
    check("R5 no strobe when off", p, 0);
    check("R5 flag off", flag, 0);
    tmo_en = 1'b1;
    low_run(16, p);
    tmo_en = 1'b0;
    step();
    check("R5 disable clears flag", flag, 0);
    // Bus idle detection
    idle_en = 1'b1;
    sda = 1'b0; step(); sda = 1'b1; step();
    for (int t = 1; t <= 11; t++) begin
      tick = 1'b1; step(); tick = 1'b0;
      step(); step();
      if (t == 10) check("R6 idle after 10 ticks", idle, 0);
    end
    check("R6 idle after 11 ticks", idle, 1);
    repeat (20) step();
    check("R6 idle holds", idle, 1);
    sda = 1'b0; step(); sda = 1'b1;
    check("R7 idle drops on sda low", idle, 0);
    for (int t = 1; t <= 10; t++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
    check("R7 count restarted", idle, 0);
    tick = 1'b1; step(); tick = 1'b0;
    check("R7 idle again", idle, 1);
    scl = 1'b0; step(); scl = 1'b1;
    check("R7 idle drops on scl low", idle, 0);
    idle_en = 1'b0;
    for (int t = 1; t <= 15; t++) begin
      tick = 1'b1; step(); tick = 1'b0;
    end
    check("R8 idle off", idle, 0);
    idle_en = 1'b1;
    step();
    check("R8 count cleared while off", idle, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule